// File: doc/BRIEF.md
# Way Replacement Controller for a Four-Way Read Cache

This block makes the replacement decisions for a small four-way set-associative read cache that sits in front of a flash bank. It keeps a valid bit and a tag for every way of every set, and it keeps a full recency order for each set. For each lookup it reports whether the access hit and in which way. On a miss it picks the way to refill and drives the valid and tag update for that way. The data array, the flash timing and the bus side are attached by the surrounding logic. That logic uses `rsp_fill`, `rsp_victim_way`, `upd_set` and `upd_tag` to write the line into its own storage.

Instruction fetches and data references can share all four ways, or they can be kept in separate pools. A 3-bit mode input selects the arrangement. Each way can be locked, and a locked way is never displaced. A per-way invalidate strobe clears the chosen ways in every set at once. When every way a request may use is locked, the miss is reported as uncached and no state changes.

The result of a lookup appears on the registered outputs one clock after the request. The tag and recency updates take effect at that same edge, so a request in the next cycle sees them.

Top module: `wrp_way_repl`

## Requirements
- R1: After reset all outputs are 0 and every entry is invalid, so the first lookup of any tag misses.
- R2: The lookup result appears on the outputs one cycle after `req_valid`. The tag is matched against the valid entries of the indexed set in all four ways, whatever the mode and access type. A match gives `rsp_hit`=1 with the way index, and no fill.
- R3: On a miss, if the allowed pool holds an invalid unlocked way, the lowest-numbered one is chosen. The response then shows `rsp_fill`=1, the victim way, `upd_set` and `upd_tag`, and the entry becomes valid with the requested tag.
- R4: If every unlocked way in the pool is valid, the victim is the least recently used of them. Both a hit and a refill make that way the most recently used of its set. After reset the order from least to most recent is ways 0, 1, 2, 3.
- R5: The pool is set by `mode`. Code 3'b000, and every code other than 3'b010 and 3'b011, lets both access types use ways 0 to 3. Code 3'b010 gives instruction fetches (`req_is_data`=0) ways 0 and 1, and data references ways 2 and 3. Code 3'b011 gives instruction fetches ways 0 to 2, and data references way 3.
- R6: A way whose `lock_mask` bit is 1 is never chosen as victim. A lookup still hits on its contents.
- R7: If every way of the allowed pool is locked, a miss gives `rsp_uncached`=1 and `rsp_fill`=0, and neither the tags nor the recency order change.
- R8: A one-cycle pulse on `inval_mask` bit w clears the valid bit and tag of way w in every set. Several bits may be set in one pulse.
- R9: When an invalidate pulse and a request fall in the same cycle, the lookup uses the contents from before the invalidate. A refill into a way cleared in that cycle does not survive, and the entry ends invalid.
- R10: Each set has its own tags and its own recency order. A fill in one set does not affect a lookup in another set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Replacement mode, which selects the way pools |
| lock_mask | input | 4 | Per-way lock, 1 = the way may not be displaced |
| inval_mask | input | 4 | Per-way invalidate strobe, acting on all sets |
| req_valid | input | 1 | A lookup is presented this cycle |
| req_set | input | SET_W | Set index of the lookup |
| req_tag | input | TAG_W | Tag of the lookup |
| req_is_data | input | 1 | 1 = data reference, 0 = instruction fetch |
| rsp_valid | output | 1 | A lookup result is on the outputs |
| rsp_hit | output | 1 | The lookup hit |
| rsp_hit_way | output | 2 | Way that hit |
| rsp_fill | output | 1 | A miss that was allocated a way |
| rsp_victim_way | output | 2 | Way that was refilled |
| rsp_uncached | output | 1 | A miss with no way available |
| upd_set | output | SET_W | Set that was written on a fill |
| upd_tag | output | TAG_W | Tag that was written on a fill |

## Verification
The cycle where an invalidate pulse meets a lookup is the case that needs care. The lookup must still hit on the old contents, and a refill chosen in that same cycle must be wiped out. The bench raises `inval_mask` in the same cycle as a request in two ways. In the first, the request hits a way that is being cleared. In the second, all four ways are cleared while the request misses and picks a victim. The bench then judges each case from the response of that cycle and from the response of a second lookup of the same tag. That second lookup must miss and must pick the lowest invalid way.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;

  typedef logic [WAYS-1:0]  way_mask_t;
  typedef logic [WAY_W-1:0] way_idx_t;

  localparam logic [2:0] MODE_SHARED   = 3'b000;
  localparam logic [2:0] MODE_SPLIT_22 = 3'b010;
  localparam logic [2:0] MODE_SPLIT_31 = 3'b011;

  // Ways an access may refill, by mode and access type (reserved codes share all ways)
  function automatic way_mask_t pool_of(input logic [2:0] mode, input logic is_data);
    case (mode)
      MODE_SPLIT_22: pool_of = is_data ? 4'b1100 : 4'b0011;
      MODE_SPLIT_31: pool_of = is_data ? 4'b1000 : 4'b0111;
      default:       pool_of = 4'b1111;
    endcase
  endfunction
endpackage

// File: rtl/wrp_tag_store.sv
module wrp_tag_store
  import wrp_pkg::*;
#(
  parameter int SETS  = 2,
  parameter int TAG_W = 15,
  parameter int SET_W = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output way_idx_t         lk_way,
  output way_mask_t        lk_valid,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  way_idx_t         wr_way,
  input  logic [TAG_W-1:0] wr_tag,
  input  way_mask_t        inval
);
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  way_mask_t        vld_q [SETS];
  way_mask_t        match;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        for (int w = 0; w < WAYS; w++) tag_q[s][w] <= '0;
      end
    end else begin
      if (wr_en) begin
        vld_q[wr_set][wr_way] <= 1'b1;
        tag_q[wr_set][wr_way] <= wr_tag;
      end
      // Invalidate is applied last so that it overrides a same-cycle fill
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          if (inval[w]) begin
            vld_q[s][w] <= 1'b0;
            tag_q[s][w] <= '0;
          end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld_q[lk_set][w] && (tag_q[lk_set][w] == lk_tag);
  end

  always_comb begin
    lk_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) lk_way = way_idx_t'(w);
  end

  assign lk_hit   = |match;
  assign lk_valid = vld_q[lk_set];
endmodule

// File: rtl/wrp_lru_ages.sv
module wrp_lru_ages
  import wrp_pkg::*;
#(
  parameter int SETS  = 2,
  parameter int SET_W = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0][WAY_W-1:0]  rd_age,
  input  logic                        touch_en,
  input  logic [SET_W-1:0]            touch_set,
  input  way_idx_t                    touch_way
);
  // Age 0 = most recently used, WAYS-1 = least recently used
  logic [WAY_W-1:0] age_q [SETS][WAYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++)
          age_q[s][w] <= WAY_W'(WAYS - 1 - w);
    end else if (touch_en) begin
      for (int w = 0; w < WAYS; w++) begin
        if (way_idx_t'(w) == touch_way)
          age_q[touch_set][w] <= '0;
        else if (age_q[touch_set][w] < age_q[touch_set][touch_way])
          age_q[touch_set][w] <= age_q[touch_set][w] + 1'b1;
      end
    end
  end

  always_comb
    for (int w = 0; w < WAYS; w++) rd_age[w] = age_q[rd_set][w];
endmodule

// File: rtl/wrp_victim_sel.sv
module wrp_victim_sel
  import wrp_pkg::*;
(
  input  way_mask_t                   pool,
  input  way_mask_t                   lock,
  input  way_mask_t                   valid,
  input  logic [WAYS-1:0][WAY_W-1:0]  age,
  output logic                        found,
  output way_idx_t                    way
);
  way_mask_t        cand;
  way_mask_t        empty;
  logic [WAY_W-1:0] best;

  assign cand  = pool & ~lock;
  assign empty = cand & ~valid;

  always_comb begin
    found = 1'b0;
    way   = '0;
    best  = '0;
    if (|empty) begin
      found = 1'b1;
      for (int w = WAYS - 1; w >= 0; w--)
        if (empty[w]) way = way_idx_t'(w);
    end else begin
      for (int w = 0; w < WAYS; w++)
        if (cand[w] && (!found || age[w] > best)) begin
          found = 1'b1;
          way   = way_idx_t'(w);
          best  = age[w];
        end
    end
  end
endmodule

// File: rtl/wrp_way_repl.sv
module wrp_way_repl
  import wrp_pkg::*;
#(
  parameter int SETS  = 2,
  parameter int TAG_W = 15,
  parameter int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       mode,
  input  logic [3:0]       lock_mask,
  input  logic [3:0]       inval_mask,
  input  logic             req_valid,
  input  logic [SET_W-1:0] req_set,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             req_is_data,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic [1:0]       rsp_hit_way,
  output logic             rsp_fill,
  output logic [1:0]       rsp_victim_way,
  output logic             rsp_uncached,
  output logic [SET_W-1:0] upd_set,
  output logic [TAG_W-1:0] upd_tag
);
  logic                       hit_c;
  way_idx_t                   hit_way_c;
  way_mask_t                  valid_c;
  logic [WAYS-1:0][WAY_W-1:0] age_c;
  logic                       vic_found;
  way_idx_t                   vic_way;
  logic                       fill_c;
  logic                       touch_c;

  wrp_tag_store #(.SETS(SETS), .TAG_W(TAG_W), .SET_W(SET_W)) u_tags (
    .clk(clk), .rst(rst),
    .lk_set(req_set), .lk_tag(req_tag),
    .lk_hit(hit_c), .lk_way(hit_way_c), .lk_valid(valid_c),
    .wr_en(fill_c), .wr_set(req_set), .wr_way(vic_way), .wr_tag(req_tag),
    .inval(inval_mask)
  );

  wrp_lru_ages #(.SETS(SETS), .SET_W(SET_W)) u_ages (
    .clk(clk), .rst(rst),
    .rd_set(req_set), .rd_age(age_c),
    .touch_en(touch_c), .touch_set(req_set),
    .touch_way(hit_c ? hit_way_c : vic_way)
  );

  wrp_victim_sel u_pick (
    .pool(pool_of(mode, req_is_data)), .lock(lock_mask), .valid(valid_c),
    .age(age_c), .found(vic_found), .way(vic_way)
  );

  assign fill_c  = req_valid && !hit_c && vic_found;
  assign touch_c = req_valid && (hit_c || vic_found);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_hit_way    <= '0;
      rsp_fill       <= 1'b0;
      rsp_victim_way <= '0;
      rsp_uncached   <= 1'b0;
      upd_set        <= '0;
      upd_tag        <= '0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_hit        <= req_valid && hit_c;
      rsp_hit_way    <= (req_valid && hit_c) ? hit_way_c : '0;
      rsp_fill       <= fill_c;
      rsp_victim_way <= fill_c ? vic_way : '0;
      rsp_uncached   <= req_valid && !hit_c && !vic_found;
      upd_set        <= fill_c ? req_set : '0;
      upd_tag        <= fill_c ? req_tag : '0;
    end
  end
endmodule

// File: rtl/wrp_way_repl_chk.sv
module wrp_way_repl_chk
  import wrp_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic [2:0] mode,
  input logic [3:0] lock_mask,
  input logic [3:0] inval_mask,
  input logic       req_valid,
  input logic       req_is_data,
  input logic       rsp_valid,
  input logic       rsp_hit,
  input logic [1:0] rsp_hit_way,
  input logic       rsp_fill,
  input logic [1:0] rsp_victim_way,
  input logic       rsp_uncached
);
  logic      req_d;
  way_mask_t lock_d, pool_d, inval_d1, inval_d2;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_d    <= 1'b0;
      lock_d   <= '0;
      pool_d   <= '0;
      inval_d1 <= '0;
      inval_d2 <= '0;
    end else begin
      req_d    <= req_valid;
      lock_d   <= lock_mask;
      pool_d   <= pool_of(mode, req_is_data);
      inval_d1 <= inval_mask;
      inval_d2 <= inval_d1;
    end
  end

  assert_resp_timing_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid == req_d);

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_fill, rsp_uncached}) == 1);

  assert_victim_in_pool_R5: assert property (@(posedge clk) disable iff (rst)
    rsp_fill |-> pool_d[rsp_victim_way]);

  assert_victim_unlocked_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_fill |-> !lock_d[rsp_victim_way]);

  assert_uncached_all_locked_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_uncached |-> (pool_d & ~lock_d) == '0);

  assert_no_hit_after_clear_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_hit |-> !inval_d2[rsp_hit_way]);
endmodule

bind wrp_way_repl wrp_way_repl_chk u_chk (
  .clk(clk), .rst(rst), .mode(mode), .lock_mask(lock_mask),
  .inval_mask(inval_mask), .req_valid(req_valid), .req_is_data(req_is_data),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_hit_way(rsp_hit_way),
  .rsp_fill(rsp_fill), .rsp_victim_way(rsp_victim_way),
  .rsp_uncached(rsp_uncached)
);

// File: tb/wrp_way_repl_tb.sv
`timescale 1ns/1ps
module wrp_way_repl_tb;
  localparam int SETS  = 2;
  localparam int TAG_W = 15;
  localparam int SET_W = 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [2:0]       mode = 3'b000;
  logic [3:0]       lock_mask = 4'b0000;
  logic [3:0]       inval_mask = 4'b0000;
  logic             req_valid = 1'b0;
  logic [SET_W-1:0] req_set = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic             req_is_data = 1'b0;
  logic             rsp_valid, rsp_hit, rsp_fill, rsp_uncached;
  logic [1:0]       rsp_hit_way, rsp_victim_way;
  logic [SET_W-1:0] upd_set;
  logic [TAG_W-1:0] upd_tag;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  wrp_way_repl #(.SETS(SETS), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst(rst), .mode(mode), .lock_mask(lock_mask),
    .inval_mask(inval_mask), .req_valid(req_valid), .req_set(req_set),
    .req_tag(req_tag), .req_is_data(req_is_data), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_hit_way(rsp_hit_way), .rsp_fill(rsp_fill),
    .rsp_victim_way(rsp_victim_way), .rsp_uncached(rsp_uncached),
    .upd_set(upd_set), .upd_tag(upd_tag)
  );

  task automatic chk(input string rq, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, got, exp);
    end
  endtask

  // One request; inv is pulsed in the same cycle. Outputs sampled at the next falling edge.
  task automatic issue(input int set, input int tag, input logic is_data, input logic [3:0] inv);
    @(negedge clk);
    req_valid   = 1'b1;
    req_set     = SET_W'(set);
    req_tag     = TAG_W'(tag);
    req_is_data = is_data;
    inval_mask  = inv;
    @(negedge clk);
    req_valid  = 1'b0;
    inval_mask = 4'b0000;
  endtask

  task automatic expect_hit(input string rq, input int set, input int tag,
                            input logic is_data, input int way, input logic [3:0] inv = 4'b0);
    issue(set, tag, is_data, inv);
    chk(rq, "rsp_valid", int'(rsp_valid), 1);
    chk(rq, "rsp_hit", int'(rsp_hit), 1);
    chk(rq, "rsp_hit_way", int'(rsp_hit_way), way);
    chk(rq, "rsp_fill", int'(rsp_fill), 0);
  endtask

  task automatic expect_fill(input string rq, input int set, input int tag,
                             input logic is_data, input int way, input logic [3:0] inv = 4'b0);
    issue(set, tag, is_data, inv);
    chk(rq, "rsp_hit", int'(rsp_hit), 0);
    chk(rq, "rsp_fill", int'(rsp_fill), 1);
    chk(rq, "rsp_victim_way", int'(rsp_victim_way), way);
    chk(rq, "upd_tag", int'(upd_tag), tag);
    chk(rq, "upd_set", int'(upd_set), set);
  endtask

  task automatic expect_uncached(input string rq, input int set, input int tag, input logic is_data);
    issue(set, tag, is_data, 4'b0);
    chk(rq, "rsp_hit", int'(rsp_hit), 0);
    chk(rq, "rsp_fill", int'(rsp_fill), 0);
    chk(rq, "rsp_uncached", int'(rsp_uncached), 1);
  endtask

  task automatic t_reset;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1", "rsp_hit after reset", int'(rsp_hit), 0);
    chk("R1", "rsp_fill after reset", int'(rsp_fill), 0);
    expect_fill("R1", 0, 'h100, 1'b0, 0);
  endtask

  task automatic t_hit_and_sets;
    expect_hit("R2", 0, 'h100, 1'b0, 0);
    expect_fill("R10", 1, 'h100, 1'b1, 0);
    expect_hit("R10", 1, 'h100, 1'b1, 0);
  endtask

  task automatic t_fill_and_lru;
    expect_fill("R3", 0, 'h101, 1'b0, 1);
    expect_fill("R3", 0, 'h102, 1'b0, 2);
    expect_fill("R3", 0, 'h103, 1'b1, 3);
    expect_hit("R4", 0, 'h101, 1'b0, 1);
    expect_fill("R4", 0, 'h200, 1'b0, 0);
    expect_fill("R4", 0, 'h201, 1'b1, 2);
  endtask

  task automatic t_lock;
    lock_mask = 4'b1000;
    expect_fill("R6", 0, 'h300, 1'b0, 1);
    expect_hit("R6", 0, 'h103, 1'b0, 3);
    lock_mask = 4'b1111;
    expect_uncached("R7", 0, 'h400, 1'b0);
    lock_mask = 4'b0000;
    // Not stored, and order unchanged: way 0 is still the oldest
    expect_fill("R7", 0, 'h400, 1'b0, 0);
  endtask

  task automatic t_modes;
    mode = 3'b010;
    expect_fill("R5", 0, 'h500, 1'b1, 2);
    expect_fill("R5", 0, 'h501, 1'b0, 1);
    mode = 3'b011;
    expect_fill("R5", 0, 'h502, 1'b1, 3);
    expect_fill("R5", 0, 'h503, 1'b0, 0);
    expect_hit("R5", 0, 'h501, 1'b1, 1);
    lock_mask = 4'b1000;
    expect_uncached("R7", 0, 'h505, 1'b1);
    lock_mask = 4'b0000;
    mode = 3'b101;
    expect_fill("R5", 0, 'h504, 1'b1, 2);
    mode = 3'b000;
  endtask

  task automatic t_invalidate;
    @(negedge clk) inval_mask = 4'b0101;
    @(negedge clk) inval_mask = 4'b0000;
    expect_fill("R8", 0, 'h503, 1'b0, 0);
    expect_fill("R8", 1, 'h100, 1'b1, 0);
    expect_hit("R8", 0, 'h501, 1'b0, 1);
    expect_fill("R8", 0, 'h600, 1'b0, 2);
  endtask

  task automatic t_same_cycle;
    expect_hit("R9", 0, 'h501, 1'b0, 1, 4'b0010);
    expect_fill("R9", 0, 'h501, 1'b0, 1);
    expect_fill("R9", 0, 'h700, 1'b0, 3, 4'b1111);
    expect_fill("R9", 0, 'h700, 1'b0, 0);
  endtask

  initial begin
    t_reset();
    t_hit_and_sets();
    t_fill_and_lru();
    t_lock();
    t_modes();
    t_invalidate();
    t_same_cycle();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule